// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the bus-facing side of a small byte-register peripheral on a two-wire I2C bus. A fast system clock oversamples SCL and SDA. The block finds Start, repeated Start and Stop conditions, and it matches its own 7-bit address. The low bit of that address comes from a strap input. SDA is modelled as an open-drain line: the block drives only a pull-low enable.

A write transaction is handled as follows:
- The first byte after the address is a command byte. It selects one of four byte registers.
- The selection persists in a pointer.
- Every data byte that follows in the same transaction is presented to the external register bank with a one-cycle write strobe.
- The strobe fires when SCL rises for the acknowledge clock of that byte.

A read is done in two steps. The master first writes only the command byte. It then issues a repeated Start (or a fresh transaction) with the read bit set. The block streams the selected register, MSB first, for as many bytes as the master acknowledges. At every acknowledge clock of a read byte, the block pulses an acknowledge-cycle strobe. A neighbouring interrupt circuit can use that strobe to clear itself.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges an address byte only when its upper 7 bits equal 0b010000 followed by the `strap_i` level (0x20 or 0x21). It acknowledges by holding SDA low for the whole high phase of the ninth clock. After a non-matching address it pulls SDA for nothing until the next Start.
- R2: Bit 0 of the address byte, sent last, selects the direction: 1 is a read and 0 is a write.
- R3: In a write transaction, the byte after the address is a command byte and is always acknowledged. Its 2 low bits set a persistent register pointer, presented on `reg_idx_o`. The upper 6 bits are ignored.
- R4: Every data byte after the command byte in a write transaction is acknowledged. Each one produces exactly one single-cycle `wr_en_o` pulse, with `wr_data_o` equal to the byte (received MSB first) and `reg_idx_o` equal to the pointer. The pulse comes at the SCL rise of that byte's ninth clock. `wr_en_o` and `ack_stb_o` are never high together.
- R5: After an acknowledged read address, the block sends `rd_data_i` for the pointed register, MSB first. For each 0 bit it pulls SDA low. The pointer set by an earlier write transaction is reused, and a read transaction never receives a command byte.
- R6: A read continues, sending `rd_data_i` again, for as long as the master acknowledges. `ack_stb_o` pulses for one cycle at the SCL rise of each read byte's ninth clock. After a master NACK, SDA is released so that the master can send Stop.
- R7: Start is SDA falling while SCL is high, and Stop is SDA rising while SCL is high. Either one in the middle of a byte abandons that byte, and a partly received data byte is never written.
- R8: While `rst` is high the block is idle and holds these conditions:
  - SDA is released.
  - No strobe fires.
  - The pointer is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| strap_i | input | 1 | Address low bit strap |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_idx_o | output | IDX_W | Register pointer for reads and writes |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Byte to write |
| rd_data_i | input | 8 | Byte of the pointed register |
| ack_stb_o | output | 1 | Pulse at each read acknowledge clock |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and a 2-bit pointer. This keeps all four registers reachable, so a command byte with the upper bits set can be shown to alias onto a low index. The bench runs the bus at 8 system clocks per SCL half-period. That gives enough margin after the synchronizer latency to sample the acknowledge and the read bits at mid-high. With these settings, the bench can cut bytes short with Start or Stop at chosen bit positions.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    localparam logic [5:0] DEV_ADDR_HI = 6'b010000;
    localparam int unsigned BITS_PER_BYTE = 8;
    localparam logic [3:0] ACK_SLOT  = 4'd8;
    localparam logic [3:0] POST_ACK  = 4'd9;

    function automatic logic addr_hit(input logic [6:0] rx_addr, input logic strap);
        return rx_addr == {DEV_ADDR_HI, strap};
    endfunction

endpackage

// File: rtl/i2c_rp_line_sync.sv
module i2c_rp_line_sync
    import i2c_regport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output line_ev_t ev
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = chain[STAGES-1] & ~chain[STAGES];
        ev.fall  = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
    import i2c_regport_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         scl,
    input  line_ev_t         sda,
    input  logic             strap,
    input  logic [7:0]       rd_data,
    output logic             pull,
    output logic [IDX_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             ack_stb
);

    phase_e      phase;
    logic [3:0]  bcnt;
    logic [7:0]  shreg;
    logic [7:0]  txbuf;
    logic        mack;
    logic        bus_start;
    logic        bus_stop;

    assign bus_start = sda.fall & scl.level;
    assign bus_stop  = sda.rise & scl.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bcnt    <= '0;
            shreg   <= '0;
            txbuf   <= '0;
            mack    <= 1'b0;
            pull    <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            ack_stb <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            ack_stb <= 1'b0;
            if (bus_start) begin
                phase <= PH_ADDR;
                bcnt  <= '0;
                pull  <= 1'b0;
            end else if (bus_stop) begin
                phase <= PH_IDLE;
                bcnt  <= '0;
                pull  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl.rise) begin
                    if (bcnt < ACK_SLOT) begin
                        bcnt <= bcnt + 4'd1;
                        if (phase != PH_RDATA) shreg <= {shreg[6:0], sda.level};
                    end else if (bcnt == ACK_SLOT) begin
                        bcnt <= POST_ACK;
                        unique case (phase)
                            PH_CMD:   ptr <= shreg[IDX_W-1:0];
                            PH_WDATA: begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                            end
                            PH_RDATA: begin
                                ack_stb <= 1'b1;
                                mack    <= ~sda.level;
                            end
                            default: ;
                        endcase
                    end
                end else if (scl.fall) begin
                    if (bcnt == ACK_SLOT) begin
                        if (phase == PH_RDATA) begin
                            pull <= 1'b0;
                        end else if (phase == PH_ADDR && !addr_hit(shreg[7:1], strap)) begin
                            phase <= PH_IDLE;
                            pull  <= 1'b0;
                        end else begin
                            pull <= 1'b1;
                        end
                    end else if (bcnt == POST_ACK) begin
                        bcnt <= '0;
                        pull <= 1'b0;
                        unique case (phase)
                            PH_ADDR: begin
                                if (shreg[0]) begin
                                    phase <= PH_RDATA;
                                    txbuf <= rd_data;
                                    pull  <= ~rd_data[7];
                                end else begin
                                    phase <= PH_CMD;
                                end
                            end
                            PH_CMD: phase <= PH_WDATA;
                            PH_RDATA: begin
                                if (mack) begin
                                    txbuf <= rd_data;
                                    pull  <= ~rd_data[7];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end else if (phase == PH_RDATA && bcnt != 4'd0) begin
                        pull <= ~txbuf[3'd7 - bcnt[2:0]];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             strap_i,
    output logic             sda_pull_o,
    output logic [IDX_W-1:0] reg_idx_o,
    output logic             wr_en_o,
    output logic [7:0]       wr_data_o,
    input  logic [7:0]       rd_data_i,
    output logic             ack_stb_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] pins;
    line_ev_t           ev [N_LINES];

    assign pins = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_rp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[g]),
            .ev  (ev[g])
        );
    end

    i2c_rp_engine #(.IDX_W(IDX_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl     (ev[0]),
        .sda     (ev[1]),
        .strap   (strap_i),
        .rd_data (rd_data_i),
        .pull    (sda_pull_o),
        .ptr     (reg_idx_o),
        .wr_en   (wr_en_o),
        .wr_data (wr_data_o),
        .ack_stb (ack_stb_o)
    );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sda_pull_o,
    input logic [IDX_W-1:0] reg_idx_o,
    input logic             wr_en_o,
    input logic             ack_stb_o
);

    AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_pull_o && !wr_en_o && !ack_stb_o && reg_idx_o == '0)); // R8

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_stb_o |=> !ack_stb_o); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && ack_stb_o)); // R4

endmodule

bind i2c_regport i2c_regport_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull_o (sda_pull_o),
    .reg_idx_o  (reg_idx_o),
    .wr_en_o    (wr_en_o),
    .ack_stb_o  (ack_stb_o)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;

    localparam int H = 8;
    localparam int Q = 2;
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{16'h01A5, 16'h023C, 16'h03FF,
                                         16'h00C3, 16'h0581, 16'h075A};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_pull;
    logic [1:0] reg_idx;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       ack_stb;
    logic [7:0] bank [4];
    logic [7:0] exp_bank [4];
    logic [7:0] rd_data;
    wire        sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int ack_cnt = 0;
    logic [1:0] last_idx;
    logic [7:0] last_data;

    always #4 clk = ~clk;

    assign rd_data = bank[reg_idx];

    i2c_regport uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .reg_idx_o  (reg_idx),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .rd_data_i  (rd_data),
        .ack_stb_o  (ack_stb)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
        end else begin
            if (wr_en) begin
                bank[reg_idx] <= wr_data;
                wr_cnt    <= wr_cnt + 1;
                last_idx  <= reg_idx;
                last_data <= wr_data;
            end
            if (ack_stb) ack_cnt <= ack_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tk(H);
        sda_m = 1'b0; tk(H);
        scl_m = 1'b0; tk(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tk(H);
        scl_m = 1'b1; tk(H);
        sda_m = 1'b0; tk(H);
        scl_m = 1'b0; tk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tk(H);
        scl_m = 1'b1; tk(H);
        sda_m = 1'b1; tk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tk(H);
            scl_m = 1'b1; tk(H);
            scl_m = 1'b0; tk(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tk(H);
        scl_m = 1'b1; tk(H / 2);
        ack = ~sda_line; tk(H / 2);
        scl_m = 1'b0; tk(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tk(H);
            scl_m = 1'b1; tk(H / 2);
            b[i] = sda_line; tk(H / 2);
            scl_m = 1'b0; tk(Q);
        end
        sda_m = ~give_ack; tk(H);
        scl_m = 1'b1; tk(H);
        scl_m = 1'b0; tk(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] wa(input logic s);
        return {6'b010000, s, 1'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] v, v2, v3;
        int wc, ac;
        for (int i = 0; i < 4; i++) exp_bank[i] = 8'h00;
        tk(5);
        chk(sda_pull == 1'b0 && wr_en == 1'b0 && ack_stb == 1'b0, "R8 reset outputs", sda_pull, 0);
        chk(reg_idx == 2'd0, "R8 reset pointer", reg_idx, 0);
        rst = 1'b0; tk(4);

        // table walk: write one byte, then read it back after a repeated Start
        for (int k = 0; k < NV; k++) begin
            wc = wr_cnt;
            bus_start();
            send_byte(wa(strap), a0);
            send_byte(VEC[k][15:8], a1);
            send_byte(VEC[k][7:0], a2);
            bus_stop();
            exp_bank[VEC[k][9:8]] = VEC[k][7:0];
            chk(a0 && a1 && a2, "R1 R3 R4 write acks", {a0, a1, a2}, 7);
            chk(wr_cnt == wc + 1 && last_idx == VEC[k][9:8] && last_data == VEC[k][7:0],
                "R4 write strobe", {last_idx, last_data}, {VEC[k][9:8], VEC[k][7:0]});
            bus_start();
            send_byte(wa(strap), a0);
            send_byte(VEC[k][15:8], a1);
            bus_rstart();
            send_byte(wa(strap) | 8'h01, a2);
            recv_byte(v, 1'b0);
            bus_stop();
            chk(a2 == 1'b1, "R2 read address ack", a2, 1);
            chk(v == exp_bank[VEC[k][9:8]], "R5 read back", v, exp_bank[VEC[k][9:8]]);
        end

        // R5: pointer persists into a read-only transaction (last command 0x07 -> index 3)
        bus_start();
        send_byte(wa(strap) | 8'h01, a0);
        recv_byte(v, 1'b0);
        bus_stop();
        chk(v == exp_bank[3], "R5 pointer persists", v, exp_bank[3]);

        // R4: several data bytes in one write all go to the selected register
        wc = wr_cnt;
        bus_start();
        send_byte(wa(strap), a0);
        send_byte(8'h02, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        send_byte(8'h33, a3);
        bus_stop();
        exp_bank[2] = 8'h33;
        chk(wr_cnt == wc + 3 && last_idx == 2'd2, "R4 burst write", wr_cnt - wc, 3);

        // R6: multi-byte read with ACK, ACK, NACK
        ac = ack_cnt;
        bus_start();
        send_byte(wa(strap) | 8'h01, a0);
        recv_byte(v, 1'b1);
        recv_byte(v2, 1'b1);
        recv_byte(v3, 1'b0);
        tk(6);
        chk(sda_pull == 1'b0, "R6 release after NACK", sda_pull, 0);
        bus_stop();
        chk(v == 8'h33 && v2 == 8'h33 && v3 == 8'h33, "R6 repeated read data", v3, 8'h33);
        chk(ack_cnt == ac + 3, "R6 ack strobe count", ack_cnt - ac, 3);

        // R1: wrong address is not acknowledged and the rest is ignored
        wc = wr_cnt;
        bus_start();
        send_byte(8'h44, a0);
        send_byte(8'h00, a1);
        send_byte(8'hEE, a2);
        bus_stop();
        chk(!a0 && !a1 && !a2, "R1 mismatch ignored", {a0, a1, a2}, 0);
        chk(wr_cnt == wc, "R1 mismatch no write", wr_cnt - wc, 0);

        // R1: strap moves the address to 0x21
        strap = 1'b1;
        bus_start();
        send_byte(wa(1'b0), a0);
        bus_stop();
        chk(a0 == 1'b0, "R1 strap high rejects 0x20", a0, 0);
        bus_start();
        send_byte(wa(1'b1), a0);
        send_byte(8'h01, a1);
        send_byte(8'h77, a2);
        bus_stop();
        exp_bank[1] = 8'h77;
        chk(a0 && a1 && a2 && last_data == 8'h77, "R1 strap high accepts 0x21", last_data, 8'h77);
        strap = 1'b0;

        // R7: Stop in the middle of a data byte
        wc = wr_cnt;
        bus_start();
        send_byte(wa(strap), a0);
        send_byte(8'h01, a1);
        send_bits(8'h00, 4);
        bus_stop();
        chk(wr_cnt == wc, "R7 stop aborts byte", wr_cnt - wc, 0);

        // R7: repeated Start in the middle of a data byte, then read
        bus_start();
        send_byte(wa(strap), a0);
        send_byte(8'h01, a1);
        send_bits(8'h00, 3);
        bus_rstart();
        send_byte(wa(strap) | 8'h01, a2);
        recv_byte(v, 1'b0);
        bus_stop();
        chk(wr_cnt == wc && a2, "R7 start aborts byte", wr_cnt - wc, 0);
        chk(v == exp_bank[1], "R7 register kept", v, exp_bank[1]);

        // R3: upper command bits ignored (0xFE -> index 2)
        bus_start();
        send_byte(wa(strap), a0);
        send_byte(8'hFE, a1);
        bus_stop();
        chk(a1 == 1'b1 && reg_idx == 2'd2, "R3 upper bits ignored", reg_idx, 2);

        // R8: reset mid-run clears the pointer
        bus_start();
        send_byte(wa(strap), a0);
        send_byte(8'h03, a1);
        bus_stop();
        rst = 1'b1; tk(3);
        chk(sda_pull == 1'b0 && wr_en == 1'b0, "R8 quiet in reset", sda_pull, 0);
        chk(reg_idx == 2'd0, "R8 pointer cleared", reg_idx, 0);
        rst = 1'b0; tk(4);
        bus_start();
        send_byte(wa(strap) | 8'h01, a0);
        recv_byte(v, 1'b0);
        bus_stop();
        chk(a0 && v == 8'h00, "R8 read after reset", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule